// File: doc/BRIEF.md
# Banked Cartridge Mapper with Interval Timer

This block sits on the CPU bus of an 8-bit console cartridge. It turns CPU writes into a small set of control registers. From those registers it produces the program-ROM address for the two 16 KB CPU windows, eight 1 KB character-bank numbers for the video side, a two-bit nametable mirroring mode and the clock and data lines of an external serial EEPROM. The ROM and RAM arrays and the EEPROM device are outside the block; the EEPROM's data-out line comes back in as an input and can be read by the CPU.

A 16-bit down-counting timer raises a level interrupt. The `LATCHED_RELOAD` parameter picks between two behaviours. With the parameter at 0, the counter byte registers write the counter directly. With the parameter at 1, they write a reload latch, and that latch is copied into the counter when the timer control register is written. In both variants the timer tests for zero before it decrements, on every clock while it is enabled.

Top module: `bank_mapper_irq`

## Requirements
- R1: A write with `cpu_we` high and `cpu_addr` in $6000–$FFFF reaches a register chosen only by `cpu_addr[3:0]`, so $6003 and $FFF3 both select character bank 3. A write below $6000 changes nothing.
- R2: Register selects 0–7 load the character bank numbers. Bank k appears on `chr_banks[8k+7:8k]`.
- R3: Select 8 keeps the low 4 bits of the data as the program bank. For `cpu_addr[14]=0`, `prg_rom_addr` is {bank, `cpu_addr[13:0]`}. For `cpu_addr[14]=1`, `prg_rom_addr` is {4'hF, `cpu_addr[13:0]`}, which is the last bank.
- R4: Select 9 loads `mirror_mode` from data bits [1:0]. The codes are 0 vertical, 1 horizontal, 2 one-screen A and 3 one-screen B.
- R5: A write to select A sets the timer enable from data bit 0 and clears any pending interrupt. When `LATCHED_RELOAD`=1, the same write copies the 16-bit reload latch into the counter.
- R6: Select B writes the low byte and select C the high byte. When `LATCHED_RELOAD`=0 they change the counter itself. When `LATCHED_RELOAD`=1 they change only the reload latch, and a running count is unaffected.
- R7: On each clock edge with the timer enabled and no timer write in that cycle, a counter of zero sets pending. The counter then decrements modulo 2^16. A counter loaded with N therefore raises `irq` after the (N+1)-th edge, and a counter of zero is followed by a full 65536-edge period.
- R8: `irq` is high while an interrupt is pending. It stays high until a write to select A or a reset.
- R9: A write to select D drives `eep_scl` from data bit 5 and `eep_sda` from data bit 6.
- R10: `cpu_rdata` is {3'b000, `eep_dout`, 4'b0000} when `cpu_addr` is in $6000–$7FFF, and zero at any other address.
- R11: After reset, all bank numbers, the counter and the latch are zero, the timer is disabled, `irq` is low, and `eep_scl` and `eep_sda` are high.
- R12: Writes to selects E and F change no output and no timer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; the timer counts on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| cpu_rdata | output | 8 | Read data for the $6000–$7FFF window |
| prg_rom_addr | output | PRG_BANK_W+14 | Program-ROM byte address |
| chr_banks | output | 8*CHR_BANK_W | Eight character bank numbers, bank 0 in the low bits |
| mirror_mode | output | 2 | Nametable mirroring code |
| irq | output | 1 | Level interrupt request |
| eep_scl | output | 1 | EEPROM serial clock |
| eep_sda | output | 1 | EEPROM serial data to the device |
| eep_dout | input | 1 | EEPROM data-out line |

## Verification
The bench times the interrupt to the exact edge after loading counts of 0, 2 and 3. A design that decremented before testing would fire one edge early, and one that missed the wrap would never fire on the second period. It runs both variants side by side. A latched design that let byte writes reach the running counter would interrupt several edges too soon, and a direct design that reloaded on a control write would fire at the wrong time. The bench also writes at high-mirror addresses, below the register window and at the two spare selects. A decoder that used more address bits, or that treated E and F as aliases, shows up as a changed bank or mirroring output.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

  localparam int NUM_CHR  = 8;
  localparam int WINDOW_W = 14;
  localparam int TIMER_W  = 16;

  localparam logic [3:0] SEL_PRG    = 4'h8;
  localparam logic [3:0] SEL_MIRROR = 4'h9;
  localparam logic [3:0] SEL_TCTRL  = 4'hA;
  localparam logic [3:0] SEL_TLO    = 4'hB;
  localparam logic [3:0] SEL_THI    = 4'hC;
  localparam logic [3:0] SEL_SERIAL = 4'hD;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  // Writes are accepted anywhere from $6000 upward.
  function automatic logic in_reg_window(input logic [15:0] a);
    return a >= 16'h6000;
  endfunction

  // Reads of the serial line live in $6000-$7FFF.
  function automatic logic in_read_window(input logic [15:0] a);
    return a[15:13] == 3'b011;
  endfunction

  function automatic logic [7:0] serial_read_byte(input logic b);
    return {3'b000, b, 4'b0000};
  endfunction

  function automatic logic [TIMER_W-1:0] merge_byte(input logic [TIMER_W-1:0] old,
                                                    input logic [7:0] b,
                                                    input logic hi);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction

  function automatic logic [TIMER_W-1:0] count_down(input logic [TIMER_W-1:0] c);
    return c - TIMER_W'(1);
  endfunction

endpackage

// File: rtl/bmap_regfile.sv
module bmap_regfile import bmap_pkg::*; #(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [3:0]                    sel,
  input  logic [7:0]                    wdata,
  output logic [NUM_CHR*CHR_BANK_W-1:0] chr_flat,
  output logic [PRG_BANK_W-1:0]         prg_bank,
  output mirror_e                       mirror,
  output logic                          scl,
  output logic                          sda
);

  logic wr_prg, wr_mirror, wr_serial, wr_spare;
  assign wr_prg    = wr_en && (sel == SEL_PRG);
  assign wr_mirror = wr_en && (sel == SEL_MIRROR);
  assign wr_serial = wr_en && (sel == SEL_SERIAL);
  assign wr_spare  = wr_en && (sel[3:1] == 3'b111);

  for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
    logic [CHR_BANK_W-1:0] bank_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         bank_q <= '0;
      else if (wr_en && sel == 4'(g))     bank_q <= wdata[CHR_BANK_W-1:0];
    end
    assign chr_flat[g*CHR_BANK_W +: CHR_BANK_W] = bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_bank <= '0;
      mirror   <= MIR_VERT;
      scl      <= 1'b1;
      sda      <= 1'b1;
    end else begin
      if (wr_prg)    prg_bank <= wdata[PRG_BANK_W-1:0];
      if (wr_mirror) mirror   <= mirror_e'(wdata[1:0]);
      if (wr_serial) begin
        scl <= wdata[5];
        sda <= wdata[6];
      end
    end
  end

  // R12: spare selects leave every register alone
  p_spare_no_effect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_spare |=> ($stable(chr_flat) && $stable(prg_bank) && $stable(mirror)
                  && $stable(scl) && $stable(sda)));

  // R9: serial lines only move on a serial-control write
  p_serial_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_serial |=> ($stable(scl) && $stable(sda)));

  // R4: mirroring only moves on its own write
  p_mirror_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mirror |=> $stable(mirror));

endmodule

// File: rtl/bmap_timer.sv
module bmap_timer import bmap_pkg::*; #(
  parameter bit LATCHED_RELOAD = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  output logic       irq
);

  logic               enabled;
  logic               pending;
  logic [TIMER_W-1:0] count;
  logic [TIMER_W-1:0] reload;

  // Named internal events for the checks below.
  logic byte_wr, direct_wr, latch_wr, tick_fire, zero_hit;
  assign byte_wr   = wr_lo || wr_hi;
  assign direct_wr = !LATCHED_RELOAD && byte_wr;
  assign latch_wr  = LATCHED_RELOAD && byte_wr;
  assign tick_fire = enabled && !wr_ctrl && !direct_wr;
  assign zero_hit  = tick_fire && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      pending <= 1'b0;
      count   <= '0;
      reload  <= '0;
    end else begin
      if (wr_ctrl) begin
        enabled <= wdata[0];
        pending <= 1'b0;
        if (LATCHED_RELOAD) count <= reload;
      end else if (direct_wr) begin
        count <= merge_byte(count, wdata, wr_hi);
      end else if (tick_fire) begin
        if (count == '0) pending <= 1'b1;
        count <= count_down(count);
      end
      if (latch_wr) reload <= merge_byte(reload, wdata, wr_hi);
    end
  end

  assign irq = pending;

  // R7: a zero seen on a tick raises pending on the next cycle
  p_zero_sets_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> irq);

  // R7: every tick takes one off the count, with wrap
  p_tick_decrements_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fire |=> (count == $past(count) - 16'd1));

  // R5: control write acknowledges
  p_ctrl_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !irq);

  // R8: pending is held until acknowledged
  p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_ctrl |=> irq);

  // R7: disabled timer stays frozen
  p_frozen_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled && !wr_ctrl && !direct_wr |=> $stable(count));

  if (LATCHED_RELOAD) begin : g_latched_chk
    // R5: control write loads the staged value
    p_latch_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (count == $past(reload)));
  end else begin : g_direct_chk
    // R6: byte writes land in the counter
    p_direct_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo && !wr_ctrl |=> (count[7:0] == $past(wdata)));
  end

endmodule

// File: rtl/bank_mapper_irq.sv
module bank_mapper_irq import bmap_pkg::*; #(
  parameter int PRG_BANK_W     = 4,
  parameter int CHR_BANK_W     = 8,
  parameter bit LATCHED_RELOAD = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [15:0]                   cpu_addr,
  input  logic [7:0]                    cpu_wdata,
  input  logic                          cpu_we,
  output logic [7:0]                    cpu_rdata,
  output logic [PRG_BANK_W+13:0]        prg_rom_addr,
  output logic [NUM_CHR*CHR_BANK_W-1:0] chr_banks,
  output logic [1:0]                    mirror_mode,
  output logic                          irq,
  output logic                          eep_scl,
  output logic                          eep_sda,
  input  logic                          eep_dout
);

  localparam int PRG_ADDR_W = PRG_BANK_W + WINDOW_W;

  logic       reg_wr;
  logic [3:0] sel;
  assign reg_wr = cpu_we && in_reg_window(cpu_addr);
  assign sel    = cpu_addr[3:0];

  logic [PRG_BANK_W-1:0] prg_bank;
  logic [PRG_BANK_W-1:0] window_bank;
  mirror_e               mirror;

  bmap_regfile #(
    .PRG_BANK_W (PRG_BANK_W),
    .CHR_BANK_W (CHR_BANK_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .sel      (sel),
    .wdata    (cpu_wdata),
    .chr_flat (chr_banks),
    .prg_bank (prg_bank),
    .mirror   (mirror),
    .scl      (eep_scl),
    .sda      (eep_sda)
  );

  bmap_timer #(
    .LATCHED_RELOAD (LATCHED_RELOAD)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (reg_wr && sel == SEL_TCTRL),
    .wr_lo   (reg_wr && sel == SEL_TLO),
    .wr_hi   (reg_wr && sel == SEL_THI),
    .wdata   (cpu_wdata),
    .irq     (irq)
  );

  // Upper 16 KB window is tied to the last bank.
  assign window_bank  = cpu_addr[14] ? '1 : prg_bank;
  assign prg_rom_addr = {window_bank, cpu_addr[WINDOW_W-1:0]};
  assign mirror_mode  = mirror;
  assign cpu_rdata    = in_read_window(cpu_addr) ? serial_read_byte(eep_dout) : 8'h00;

  // R3: the upper window always shows the last bank
  p_fixed_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:14] == 2'b11 |-> (prg_rom_addr[PRG_ADDR_W-1:WINDOW_W] == '1));

  // R10: nothing is returned outside the read window
  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:13] != 3'b011 |-> (cpu_rdata == 8'h00));

  // R1: writes below the window never disturb the bank outputs
  p_low_write_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && cpu_addr < 16'h6000 |=> ($stable(chr_banks) && $stable(mirror_mode)));

endmodule

// File: tb/test_bank_mapper_irq.sv
module test_bank_mapper_irq;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic        eep_dout = 1'b0;

  logic [7:0]  rdata_l, rdata_d;
  logic [17:0] prg_l, prg_d;
  logic [63:0] chr_l, chr_d;
  logic [1:0]  mir_l, mir_d;
  logic        irq_l, irq_d, scl_l, scl_d, sda_l, sda_d;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  bank_mapper_irq #(.LATCHED_RELOAD(1'b1)) i_bank_mapper_irq (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(rdata_l), .prg_rom_addr(prg_l), .chr_banks(chr_l),
    .mirror_mode(mir_l), .irq(irq_l), .eep_scl(scl_l), .eep_sda(sda_l),
    .eep_dout(eep_dout)
  );

  bank_mapper_irq #(.LATCHED_RELOAD(1'b0)) i_bank_mapper_irq_direct (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(rdata_d), .prg_rom_addr(prg_d), .chr_banks(chr_d),
    .mirror_mode(mir_d), .irq(irq_d), .eep_scl(scl_d), .eep_sda(sda_d),
    .eep_dout(eep_dout)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    cpu_we = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] chr_of(input logic [63:0] f, input int k);
    return f[k*8 +: 8];
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R11 chr", chr_l, 64'h0);
    cpu_addr = 16'h8000; #1;
    chk("R11 prg", prg_l, 18'h0);
    cpu_addr = 16'h0000;
    chk("R11 mirror", mir_l, 2'd0);
    chk("R11 irq", {irq_l, irq_d}, 2'b00);
    chk("R11 scl/sda", {scl_l, sda_l, scl_d, sda_d}, 4'hF);
    tick(5);
    chk("R11 timer off", {irq_l, irq_d}, 2'b00);
  endtask

  task automatic t_decode_window();
    do_reset();
    wr(16'h6003, 8'h11);
    chk("R1 low mirror", chr_of(chr_l, 3), 8'h11);
    wr(16'hFFF3, 8'h22);
    chk("R1 high mirror", chr_of(chr_l, 3), 8'h22);
    wr(16'h5003, 8'h99);
    chk("R1 below window", chr_of(chr_l, 3), 8'h22);
    wr(16'h4FF9, 8'h03);
    chk("R1 below window mirror", mir_l, 2'd0);
  endtask

  task automatic t_chr_banks();
    do_reset();
    for (int k = 0; k < 8; k++) wr(16'hA000 + 16'(k), 8'(8'h30 + k * 17));
    for (int k = 0; k < 8; k++) chk("R2 chr bank", chr_of(chr_l, k), 8'(8'h30 + k * 17));
  endtask

  task automatic t_prg();
    do_reset();
    wr(16'h8008, 8'h37);
    cpu_addr = 16'h8123; #1;
    chk("R3 low window", prg_l, {4'h7, 14'h0123});
    cpu_addr = 16'hC456; #1;
    chk("R3 fixed window", prg_l, {4'hF, 14'h0456});
    wr(16'h7FF8, 8'hF9);
    cpu_addr = 16'hBFFF; #1;
    chk("R3 four bits kept", prg_l, {4'h9, 14'h3FFF});
    cpu_addr = 16'h0000;
  endtask

  task automatic t_mirror();
    do_reset();
    wr(16'h8009, 8'hFE);
    chk("R4 one-screen A", mir_l, 2'd2);
    wr(16'h8009, 8'h01);
    chk("R4 horizontal", mir_l, 2'd1);
    wr(16'h8009, 8'h03);
    chk("R4 one-screen B", mir_l, 2'd3);
  endtask

  task automatic t_latched_timer();
    do_reset();
    wr(16'h800B, 8'h03);
    wr(16'h800C, 8'h00);
    wr(16'h800A, 8'h01);          // counter := 3
    tick(3);
    chk("R7 count 3 before fire", irq_l, 1'b0);
    tick(1);
    chk("R7 count 3 fires", irq_l, 1'b1);
    tick(10);
    chk("R8 level held", irq_l, 1'b1);
    wr(16'h800B, 8'h05);          // latch := 5
    chk("R8 byte write no ack", irq_l, 1'b1);
    wr(16'h800A, 8'h01);          // ack, counter := 5
    chk("R5 ack clears", irq_l, 1'b0);
    wr(16'h800B, 8'h00);          // latch only; counter keeps running
    tick(4);
    chk("R6 latch write leaves count", irq_l, 1'b0);
    tick(1);
    chk("R6 fires on original count", irq_l, 1'b1);
    wr(16'h800A, 8'h01);          // counter := latch 0
    chk("R5 ack again", irq_l, 1'b0);
    tick(1);
    chk("R5 latch copied", irq_l, 1'b1);
    wr(16'h800A, 8'h00);
    tick(3);
    chk("R5 disable", irq_l, 1'b0);
    do_reset();
    chk("R8 reset clears", irq_l, 1'b0);
  endtask

  task automatic t_direct_timer();
    do_reset();
    wr(16'h800B, 8'h02);
    wr(16'h800A, 8'h01);          // no copy in this variant: counter stays 2
    tick(2);
    chk("R6 direct before fire", irq_d, 1'b0);
    tick(1);
    chk("R6 direct fires", irq_d, 1'b1);
  endtask

  task automatic t_wrap();
    do_reset();
    wr(16'h800B, 8'h00);
    wr(16'h800C, 8'h00);
    wr(16'h800A, 8'h01);
    chk("R7 zero not yet", irq_d, 1'b0);
    tick(1);
    chk("R7 zero fires at once", irq_d, 1'b1);
    wr(16'h800A, 8'h01);          // ack; counter is now FFFF
    chk("R5 direct ack", irq_d, 1'b0);
    tick(65535);
    chk("R7 wrap not early", irq_d, 1'b0);
    tick(1);
    chk("R7 wrap period", irq_d, 1'b1);
  endtask

  task automatic t_serial();
    do_reset();
    wr(16'h800D, 8'h20);
    chk("R9 scl1 sda0", {scl_l, sda_l}, 2'b10);
    wr(16'h800D, 8'h40);
    chk("R9 scl0 sda1", {scl_l, sda_l}, 2'b01);
    wr(16'h600D, 8'h9F);
    chk("R9 both low", {scl_l, sda_l}, 2'b00);
    wr(16'hE00D, 8'h60);
    chk("R9 both high", {scl_l, sda_l}, 2'b11);
  endtask

  task automatic t_read();
    eep_dout = 1'b1;
    cpu_addr = 16'h6000; #1;
    chk("R10 bit4 set", rdata_l, 8'h10);
    cpu_addr = 16'h7FFF; #1;
    chk("R10 window top", rdata_l, 8'h10);
    cpu_addr = 16'h8000; #1;
    chk("R10 outside window", rdata_l, 8'h00);
    cpu_addr = 16'h5FFF; #1;
    chk("R10 below window", rdata_l, 8'h00);
    eep_dout = 1'b0;
    cpu_addr = 16'h6ABC; #1;
    chk("R10 bit4 clear", rdata_l, 8'h00);
    cpu_addr = 16'h0000;
  endtask

  task automatic t_spare();
    logic [63:0] chr_s;
    logic [1:0]  mir_s;
    do_reset();
    wr(16'h8000, 8'hA5);
    wr(16'h8008, 8'h02);
    wr(16'h8009, 8'h01);
    chr_s = chr_l; mir_s = mir_l;
    wr(16'h800E, 8'hFF);
    wr(16'hC00F, 8'hFF);
    chk("R12 chr", chr_l, chr_s);
    chk("R12 mirror", mir_l, mir_s);
    chk("R12 serial", {scl_l, sda_l}, 2'b11);
    cpu_addr = 16'h8000; #1;
    chk("R12 prg", prg_l, {4'h2, 14'h0});
    cpu_addr = 16'h0000;
    tick(3);
    chk("R12 timer untouched", {irq_l, irq_d}, 2'b00);
  endtask

  initial begin
    t_reset();
    t_decode_window();
    t_chr_banks();
    t_prg();
    t_mirror();
    t_latched_timer();
    t_direct_timer();
    t_wrap();
    t_serial();
    t_read();
    t_spare();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule